// File: doc/BRIEF.md
# DVFS Clock Transition Sequencer

This block moves a core clock domain from one of sixteen performance levels to another. Level 0 is the fastest point, 1700 MHz. Each higher index is 100 MHz slower, down to 200 MHz at level 15. A one-cycle start pulse carries the current and the target level. The sequencer looks up the divider settings and the PLL multiplier, pre-divider and post-divider for those levels in internal tables. It then issues a series of single-cycle register writes to a divider block, a core clock mux and a PLL controller. Between writes it waits on the status those blocks return. When the sequence is complete it pulses done.

The order of the steps depends on the direction of the change. When the clock speeds up, the dividers are reprogrammed before the PLL. When it slows down, the PLL goes first. If the two levels share the multiplier and pre-divider, the PLL step rewrites only the post-divider. Otherwise the core is parked on a fixed secondary PLL while the main PLL relocks. Every wait is bounded by a timeout. An expired wait leaves a sticky error flag and returns the sequencer to idle.

Top module: `dvfs_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, err_o and wr_valid_o are all low until a start pulse arrives.
- R2: If the start pulse carries equal current and target levels, no write is issued, and done_o pulses two cycles after the start cycle.
- R3: When the target index is below the current index (speed-up), both divider writes complete before the first PLL-related write.
- R4: When the target index is above the current index (slow-down), the PLL step completes before the first divider write.
- R5: If the multiplier and pre-divider of the two levels are equal, the PLL step is a single write with target code 5, carrying the 3-bit post-divider in data bits 2:0.
- R6: Otherwise the PLL step issues these writes in order. First a mux write (code 2, data 1) selects the secondary PLL, followed by a wait for mux status 2. Then a lock-time write (code 3) carries pre-divider times 250. Next a PLL word write (code 4) carries the multiplier at bits 25:16, the pre-divider at 13:8 and the post-divider at 2:0, followed by a wait for the lock input. Last, a mux write (code 2, data 0) selects the main PLL, followed by a wait for mux status 1.
- R7: A divider update writes the first word (code 0) and waits until all eight busy bits are clear. It then writes the second word (code 1) and waits until both of its busy bits are clear. Each word holds 3-bit ratios in 4-bit slots starting at bit 0. The second word is 0x00000020 at every level.
- R8: The PLL word for level L satisfies 24 MHz x multiplier / (pre-divider x 2^post-divider) = (1700 - 100 x L) MHz. The first divider word follows the per-level table that the bench holds.
- R9: No write is issued while the status awaited from the previous write is still unsatisfied.
- R10: A start pulse that arrives while busy_o is high is ignored.
- R11: done_o is high for exactly one cycle per completed transition.
- R12: A wait that stays unsatisfied for TIMEOUT cycles sets err_o and returns to idle without a done pulse. err_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to change level |
| old_lvl_i | input | 4 | Current level index |
| new_lvl_i | input | 4 | Target level index |
| busy_o | output | 1 | Sequencer is not idle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout flag |
| wr_valid_o | output | 1 | Write strobe, one cycle per write |
| wr_sel_o | output | 3 | Write target: 0 div word 1, 1 div word 2, 2 core mux, 3 lock time, 4 PLL word, 5 post-divider only |
| wr_data_o | output | 32 | Write data |
| div0_busy_i | input | 8 | Per-ratio busy bits of the first divider word |
| div1_busy_i | input | 2 | Per-ratio busy bits of the second divider word |
| mux_stat_i | input | 3 | Core mux status: 1 on main PLL, 2 on secondary PLL |
| pll_lock_i | input | 1 | Main PLL lock indication |

## Verification
The checker assumes that a status input, once it reaches the value a wait expects, holds that value into the following write cycle. It also assumes that the neighbouring blocks raise busy, or leave the mux and lock states, in the same cycle as the write that starts them. The bench environment model meets both assumptions. It raises each status change on the write cycle itself and releases it only after a fixed delay, so a wait can never see the previous step's stale value. The stimulus pulses start only while the sequencer is idle, except in the one test that deliberately checks that a start during busy is ignored. It holds a divider busy bit stuck only in the timeout test.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

    localparam int LVL_W      = 4;
    localparam int NUM_LVL    = 1 << LVL_W;
    localparam int DATA_W     = 32;
    localparam int NUM_DIV0   = 8;
    localparam int NUM_DIV1   = 2;
    localparam int SLOT_W     = 4;
    localparam int RATIO_W    = 3;
    localparam int MUL_W      = 10;
    localparam int PRE_W      = 6;
    localparam int POST_W     = 3;

    localparam logic [2:0] MUX_ON_MAIN = 3'd1;
    localparam logic [2:0] MUX_ON_ALT  = 3'd2;

    typedef enum logic [2:0] {
        TGT_DIV0 = 3'd0,
        TGT_DIV1 = 3'd1,
        TGT_MUX  = 3'd2,
        TGT_LOCK = 3'd3,
        TGT_PLL  = 3'd4,
        TGT_POST = 3'd5
    } tgt_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_DIV0_WR,
        ST_DIV0_WAIT,
        ST_DIV1_WR,
        ST_DIV1_WAIT,
        ST_ALT_WR,
        ST_ALT_WAIT,
        ST_LOCK_WR,
        ST_PLL_WR,
        ST_LOCK_WAIT,
        ST_MAIN_WR,
        ST_MAIN_WAIT,
        ST_POST_WR,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [MUL_W-1:0]  mul;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } pll_cfg_t;

endpackage

// File: rtl/dvfs_pll_rom.sv
module dvfs_pll_rom
    import dvfs_seq_pkg::*;
(
    input  logic [LVL_W-1:0] lvl_i,
    output pll_cfg_t         cfg_o
);

    always_comb begin
        cfg_o = '0;
        unique case (lvl_i)
            4'd0:  cfg_o = '{mul: 10'd425, pre: 6'd6, post: 3'd0};
            4'd1:  cfg_o = '{mul: 10'd200, pre: 6'd3, post: 3'd0};
            4'd2:  cfg_o = '{mul: 10'd250, pre: 6'd4, post: 3'd0};
            4'd3:  cfg_o = '{mul: 10'd175, pre: 6'd3, post: 3'd0};
            4'd4:  cfg_o = '{mul: 10'd325, pre: 6'd6, post: 3'd0};
            4'd5:  cfg_o = '{mul: 10'd200, pre: 6'd4, post: 3'd0};
            4'd6:  cfg_o = '{mul: 10'd275, pre: 6'd6, post: 3'd0};
            4'd7:  cfg_o = '{mul: 10'd125, pre: 6'd3, post: 3'd0};
            4'd8:  cfg_o = '{mul: 10'd150, pre: 6'd4, post: 3'd0};
            4'd9:  cfg_o = '{mul: 10'd100, pre: 6'd3, post: 3'd0};
            4'd10: cfg_o = '{mul: 10'd175, pre: 6'd3, post: 3'd1};
            4'd11: cfg_o = '{mul: 10'd200, pre: 6'd4, post: 3'd1};
            4'd12: cfg_o = '{mul: 10'd125, pre: 6'd3, post: 3'd1};
            4'd13: cfg_o = '{mul: 10'd100, pre: 6'd3, post: 3'd1};
            4'd14: cfg_o = '{mul: 10'd200, pre: 6'd4, post: 3'd2};
            default: cfg_o = '{mul: 10'd100, pre: 6'd3, post: 3'd2};
        endcase
    end

endmodule

// File: rtl/dvfs_div_rom.sv
module dvfs_div_rom
    import dvfs_seq_pkg::*;
(
    input  logic [LVL_W-1:0]           lvl_i,
    output logic [NUM_DIV0*SLOT_W-1:0] div0_o,
    output logic [NUM_DIV1*SLOT_W-1:0] div1_o
);

    logic [RATIO_W-1:0] r0 [NUM_DIV0];
    logic [RATIO_W-1:0] r1 [NUM_DIV1];

    // slot order: core, core-side bus, coherency port, peripheral,
    // trace bus, debug APB, PLL output, second core ratio
    always_comb begin
        r0[0] = 3'd0;
        r0[2] = 3'd7;
        r0[3] = 3'd7;
        r0[7] = 3'd0;

        if (lvl_i <= 4'd1 || lvl_i == 4'd6) r0[1] = 3'd3;
        else if (lvl_i <= 4'd5)             r0[1] = 3'd2;
        else                                r0[1] = 3'd1;

        if      (lvl_i <= 4'd2)  r0[4] = 3'd7;
        else if (lvl_i <= 4'd4)  r0[4] = 3'd6;
        else if (lvl_i <= 4'd6)  r0[4] = 3'd5;
        else if (lvl_i <= 4'd9)  r0[4] = 3'd4;
        else if (lvl_i <= 4'd11) r0[4] = 3'd3;
        else if (lvl_i <= 4'd13) r0[4] = 3'd2;
        else                     r0[4] = 3'd1;

        r0[5] = (lvl_i == 4'd0) ? 3'd3 : 3'd1;

        if      (lvl_i == 4'd0) r0[6] = 3'd5;
        else if (lvl_i <= 4'd3) r0[6] = 3'd4;
        else if (lvl_i <= 4'd6) r0[6] = 3'd3;
        else if (lvl_i <= 4'd9) r0[6] = 3'd2;
        else                    r0[6] = 3'd1;

        r1[0] = 3'd0;
        r1[1] = 3'd2;
    end

    for (genvar g = 0; g < NUM_DIV0; g++) begin : g_pack0
        assign div0_o[g*SLOT_W +: SLOT_W] = {{(SLOT_W-RATIO_W){1'b0}}, r0[g]};
    end

    for (genvar g = 0; g < NUM_DIV1; g++) begin : g_pack1
        assign div1_o[g*SLOT_W +: SLOT_W] = {{(SLOT_W-RATIO_W){1'b0}}, r1[g]};
    end

endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = run_i ? cnt_q + 1'b1 : '0;
        expired_o = run_i && (cnt_q == CNT_W'(TIMEOUT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_seq_pkg::*;
#(
    parameter int TIMEOUT    = 4096,
    parameter int LOCK_PER_P = 250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LVL_W-1:0]    old_lvl_i,
    input  logic [LVL_W-1:0]    new_lvl_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                wr_valid_o,
    output logic [2:0]          wr_sel_o,
    output logic [DATA_W-1:0]   wr_data_o,
    input  logic [NUM_DIV0-1:0] div0_busy_i,
    input  logic [NUM_DIV1-1:0] div1_busy_i,
    input  logic [2:0]          mux_stat_i,
    input  logic                pll_lock_i
);

    localparam logic [$bits(pll_cfg_t)-1:0] RELOCK_MASK =
        {{MUL_W{1'b1}}, {PRE_W{1'b1}}, {POST_W{1'b0}}};

    typedef struct packed {
        state_e           st;
        logic [LVL_W-1:0] old_lvl;
        logic [LVL_W-1:0] new_lvl;
        logic             div_pend;
        logic             pll_pend;
        logic             err;
    } seq_t;

    seq_t q, d;

    pll_cfg_t                   old_cfg, new_cfg;
    logic [NUM_DIV0*SLOT_W-1:0] div0_word;
    logic [NUM_DIV1*SLOT_W-1:0] div1_word;
    logic                       relock;
    logic                       in_wait, wait_ok, expired;
    state_e                     pll_entry;

    dvfs_pll_rom u_pll_old (.lvl_i(q.old_lvl), .cfg_o(old_cfg));
    dvfs_pll_rom u_pll_new (.lvl_i(q.new_lvl), .cfg_o(new_cfg));

    dvfs_div_rom u_div (
        .lvl_i  (q.new_lvl),
        .div0_o (div0_word),
        .div1_o (div1_word)
    );

    dvfs_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_wait && !wait_ok),
        .expired_o (expired)
    );

    assign relock    = ((old_cfg ^ new_cfg) & RELOCK_MASK) != '0;
    assign pll_entry = relock ? ST_ALT_WR : ST_POST_WR;

    // wait condition per state
    always_comb begin
        in_wait = 1'b1;
        wait_ok = 1'b0;
        unique case (q.st)
            ST_DIV0_WAIT: wait_ok = (div0_busy_i == '0);
            ST_DIV1_WAIT: wait_ok = (div1_busy_i == '0);
            ST_ALT_WAIT:  wait_ok = (mux_stat_i == MUX_ON_ALT);
            ST_LOCK_WAIT: wait_ok = pll_lock_i;
            ST_MAIN_WAIT: wait_ok = (mux_stat_i == MUX_ON_MAIN);
            default:      in_wait = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.old_lvl = old_lvl_i;
                    d.new_lvl = new_lvl_i;
                    d.st      = ST_ROUTE;
                end
            end
            ST_ROUTE: begin
                if (q.new_lvl == q.old_lvl) begin
                    d.st = ST_DONE;
                end else begin
                    d.div_pend = 1'b1;
                    d.pll_pend = 1'b1;
                    d.st       = (q.new_lvl < q.old_lvl) ? ST_DIV0_WR : pll_entry;
                end
            end
            ST_DIV0_WR:   d.st = ST_DIV0_WAIT;
            ST_DIV0_WAIT: if (wait_ok) d.st = ST_DIV1_WR;
            ST_DIV1_WR:   d.st = ST_DIV1_WAIT;
            ST_DIV1_WAIT: begin
                if (wait_ok) begin
                    d.div_pend = 1'b0;
                    d.st       = q.pll_pend ? pll_entry : ST_DONE;
                end
            end
            ST_ALT_WR:    d.st = ST_ALT_WAIT;
            ST_ALT_WAIT:  if (wait_ok) d.st = ST_LOCK_WR;
            ST_LOCK_WR:   d.st = ST_PLL_WR;
            ST_PLL_WR:    d.st = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (wait_ok) d.st = ST_MAIN_WR;
            ST_MAIN_WR:   d.st = ST_MAIN_WAIT;
            ST_MAIN_WAIT: begin
                if (wait_ok) begin
                    d.pll_pend = 1'b0;
                    d.st       = q.div_pend ? ST_DIV0_WR : ST_DONE;
                end
            end
            ST_POST_WR: begin
                d.pll_pend = 1'b0;
                d.st       = q.div_pend ? ST_DIV0_WR : ST_DONE;
            end
            ST_DONE:      d.st = ST_IDLE;
            default:      d.st = ST_IDLE;
        endcase

        if (in_wait && !wait_ok && expired) begin
            d.st       = ST_IDLE;
            d.err      = 1'b1;
            d.div_pend = 1'b0;
            d.pll_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, old_lvl: '0, new_lvl: '0,
                   div_pend: 1'b0, pll_pend: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    // write port decode
    always_comb begin
        tgt_e sel;
        sel        = TGT_DIV0;
        wr_valid_o = 1'b1;
        wr_data_o  = '0;
        unique case (q.st)
            ST_DIV0_WR: begin
                sel       = TGT_DIV0;
                wr_data_o = DATA_W'(div0_word);
            end
            ST_DIV1_WR: begin
                sel       = TGT_DIV1;
                wr_data_o = DATA_W'(div1_word);
            end
            ST_ALT_WR: begin
                sel       = TGT_MUX;
                wr_data_o = 32'd1;
            end
            ST_LOCK_WR: begin
                sel       = TGT_LOCK;
                wr_data_o = DATA_W'(new_cfg.pre) * DATA_W'(LOCK_PER_P);
            end
            ST_PLL_WR: begin
                sel       = TGT_PLL;
                wr_data_o = {6'd0, new_cfg.mul, 2'd0, new_cfg.pre, 5'd0, new_cfg.post};
            end
            ST_MAIN_WR: begin
                sel       = TGT_MUX;
                wr_data_o = 32'd0;
            end
            ST_POST_WR: begin
                sel       = TGT_POST;
                wr_data_o = DATA_W'(new_cfg.post);
            end
            default: wr_valid_o = 1'b0;
        endcase
        wr_sel_o = sel;
    end

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = (q.st == ST_DONE);
    assign err_o  = q.err;

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk
    import dvfs_seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [LVL_W-1:0]    old_lvl_i,
    input logic [LVL_W-1:0]    new_lvl_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                err_o,
    input logic                wr_valid_o,
    input logic [2:0]          wr_sel_o,
    input logic [DATA_W-1:0]   wr_data_o,
    input logic [NUM_DIV0-1:0] div0_busy_i,
    input logic [2:0]          mux_stat_i,
    input logic                pll_lock_i
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R12

    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!done_o && !busy_o)); // R12

    AST_EQUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (old_lvl_i == new_lvl_i))
            |-> ##1 !wr_valid_o ##1 (done_o && !wr_valid_o)); // R2

    AST_DIV1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_sel_o == TGT_DIV1) |-> ($past(div0_busy_i) == '0)); // R9

    AST_LOCK_AFTER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_sel_o == TGT_LOCK) |-> ($past(mux_stat_i) == MUX_ON_ALT)); // R6

    AST_MAIN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_sel_o == TGT_MUX && wr_data_o == '0) |-> $past(pll_lock_i)); // R6

    AST_MUX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_sel_o == TGT_MUX) |-> (wr_data_o <= 32'd1)); // R6

endmodule

bind dvfs_seq dvfs_seq_chk u_chk (.*);

// File: tb/dvfs_seq_test.sv
module dvfs_seq_test;

    localparam int TMO = 20;
    localparam int DLY = 3;
    localparam int LOCK_DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  old_lvl = '0, new_lvl = '0;
    logic        busy, done, err, wr_valid;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic [7:0]  div0_busy;
    logic [1:0]  div1_busy;
    logic [2:0]  mux_stat;
    logic        pll_lock;

    int checks = 0;
    int errors = 0;

    dvfs_seq #(.TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .old_lvl_i(old_lvl), .new_lvl_i(new_lvl),
        .busy_o(busy), .done_o(done), .err_o(err),
        .wr_valid_o(wr_valid), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
        .div0_busy_i(div0_busy), .div1_busy_i(div1_busy),
        .mux_stat_i(mux_stat), .pll_lock_i(pll_lock)
    );

    always #10 clk = ~clk;

    // environment model and write log
    int   d0_cnt = 0, d1_cnt = 0, mux_cnt = 0, lk_cnt = 0;
    logic [2:0] mux_tgt = 3'd1;
    bit   stuck = 1'b0;
    int   log_n = 0, done_cnt = 0, viol = 0, dbl = 0;
    logic [2:0]  log_sel  [16];
    logic [31:0] log_data [16];
    bit   done_prev = 1'b0;

    initial begin
        mux_stat  = 3'd1;
        pll_lock  = 1'b1;
        div0_busy = '0;
        div1_busy = '0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            d0_cnt = 0; d1_cnt = 0; mux_cnt = 0; lk_cnt = 0;
            mux_stat = 3'd1; pll_lock = 1'b1; done_prev = 1'b0;
        end else begin
            if (done) done_cnt++;
            if (done && done_prev) dbl++;
            done_prev = done;
            if (wr_valid) begin
                if (d0_cnt > 0 || d1_cnt > 0 || mux_cnt > 0 || lk_cnt > 0 || stuck) viol++;
                if (log_n < 16) begin
                    log_sel[log_n]  = wr_sel;
                    log_data[log_n] = wr_data;
                end
                log_n++;
            end
            if (d0_cnt > 0) d0_cnt--;
            if (d1_cnt > 0) d1_cnt--;
            if (mux_cnt > 0) begin
                mux_cnt--;
                if (mux_cnt == 0) mux_stat = mux_tgt;
            end
            if (lk_cnt > 0) begin
                lk_cnt--;
                if (lk_cnt == 0) pll_lock = 1'b1;
            end
            if (wr_valid) begin
                case (wr_sel)
                    3'd0: d0_cnt = DLY;
                    3'd1: d1_cnt = DLY;
                    3'd2: begin
                        mux_tgt  = wr_data[0] ? 3'd2 : 3'd1;
                        mux_stat = 3'd4;
                        mux_cnt  = DLY;
                    end
                    3'd4: begin
                        pll_lock = 1'b0;
                        lk_cnt   = LOCK_DLY;
                    end
                    default: ;
                endcase
            end
        end
        div0_busy = (d0_cnt > 0 || stuck) ? 8'h11 : 8'h00;
        div1_busy = (d1_cnt > 0) ? 2'b10 : 2'b00;
    end

    // bench-side tables
    function automatic int bm(input int l);
        case (l)
            0: return 425;  1: return 200;  2: return 250;  3: return 175;
            4: return 325;  5: return 200;  6: return 275;  7: return 125;
            8: return 150;  9: return 100; 10: return 175; 11: return 200;
            12: return 125; 13: return 100; 14: return 200; default: return 100;
        endcase
    endfunction

    function automatic int bp(input int l);
        case (l)
            0, 4, 6: return 6;
            2, 5, 8, 11, 14: return 4;
            default: return 3;
        endcase
    endfunction

    function automatic int bs(input int l);
        if (l >= 14) return 2;
        if (l >= 10) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] bdiv0(input int l);
        case (l)
            0: return 32'h05377730;  1: return 32'h04177730;
            2: return 32'h04177720;  3: return 32'h04167720;
            4: return 32'h03167720;  5: return 32'h03157720;
            6: return 32'h03157730;  7, 8, 9: return 32'h02147710;
            10, 11: return 32'h01137710;
            12, 13: return 32'h01127710;
            default: return 32'h01117710;
        endcase
    endfunction

    int          exp_n;
    logic [2:0]  exp_sel  [16];
    logic [31:0] exp_data [16];

    task automatic push(input logic [2:0] s, input logic [31:0] dat);
        exp_sel[exp_n]  = s;
        exp_data[exp_n] = dat;
        exp_n++;
    endtask

    task automatic push_div(input int n);
        push(3'd0, bdiv0(n));
        push(3'd1, 32'h20);
    endtask

    task automatic push_pll(input int o, input int n);
        if (bm(o) != bm(n) || bp(o) != bp(n)) begin
            push(3'd2, 32'd1);
            push(3'd3, 32'(bp(n) * 250));
            push(3'd4, 32'((bm(n) << 16) | (bp(n) << 8) | bs(n)));
            push(3'd2, 32'd0);
        end else begin
            push(3'd5, 32'(bs(n)));
        end
    endtask

    task automatic build_exp(input int o, input int n);
        exp_n = 0;
        if (n < o) begin
            push_div(n);
            push_pll(o, n);
        end else if (n > o) begin
            push_pll(o, n);
            push_div(n);
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic compare_log(input string tag);
        int bad;
        bad = -1;
        if (log_n != exp_n) bad = 99;
        else
            for (int i = 0; i < exp_n; i++)
                if (bad < 0 && (log_sel[i] != exp_sel[i] || log_data[i] != exp_data[i])) bad = i;
        if (bad == 99)
            check(1'b0, tag, "write count", log_n, exp_n);
        else if (bad >= 0)
            check(1'b0, tag, $sformatf("write %0d sel/data", bad),
                  {log_sel[bad], log_data[bad]}, {exp_sel[bad], exp_data[bad]});
        else
            check(1'b1, tag, "", 0, 0);
    endtask

    task automatic run_xfer(input int o, input int n, input int extra_at, output int cyc);
        log_n = 0; done_cnt = 0; viol = 0; dbl = 0;
        old_lvl = 4'(o); new_lvl = 4'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 2000) begin
            if (cyc == extra_at) begin
                old_lvl = 4'(n); new_lvl = 4'(o); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        string tag;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !wr_valid, "R1", "outputs in reset",
              {busy, done, err, wr_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !wr_valid, "R1", "outputs after reset",
              {busy, done, err, wr_valid}, 0);

        // R8: bench PLL table gives the stated frequency ladder
        for (int l = 0; l < 16; l++)
            check(24 * bm(l) == (1700 - 100 * l) * bp(l) * (1 << bs(l)), "R8",
                  $sformatf("freq level %0d", l), 24 * bm(l) / (bp(l) << bs(l)), 1700 - 100 * l);

        // full sweep of all level pairs: R2 R3 R4 R5 R6 R7 R9 R11
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 16; n++) begin
                build_exp(o, n);
                run_xfer(o, n, -1, cyc);
                if (o == n) tag = "R2";
                else if (n < o) tag = (bm(o) != bm(n) || bp(o) != bp(n)) ? "R3 R6 R7 R8" : "R3 R5 R7 R8";
                else tag = (bm(o) != bm(n) || bp(o) != bp(n)) ? "R4 R6 R7 R8" : "R4 R5 R7 R8";
                compare_log($sformatf("%s %0d->%0d", tag, o, n));
                check(done_cnt == 1 && dbl == 0, "R11", $sformatf("done pulse %0d->%0d", o, n),
                      done_cnt, 1);
                check(viol == 0 && !err, "R9", $sformatf("gated writes %0d->%0d", o, n), viol, 0);
            end
        end

        // R10: start during busy is ignored
        build_exp(15, 0);
        run_xfer(15, 0, 3, cyc);
        compare_log("R10 start while busy");
        check(done_cnt == 1, "R10", "single done", done_cnt, 1);
        repeat (4) @(negedge clk);
        check(!busy && log_n == exp_n, "R10", "idle after ignored start", log_n, exp_n);

        // R12: timeout on a stuck divider
        stuck = 1'b1;
        run_xfer(15, 0, -1, cyc);
        check(err == 1'b1, "R12", "error flag set", err, 1);
        check(done_cnt == 0 && !busy, "R12", "no done, idle", done_cnt, 0);
        check(log_n == 1, "R12", "writes before timeout", log_n, 1);
        check(cyc >= TMO && cyc <= TMO + 4, "R12", "timeout length", cyc, TMO + 2);
        stuck = 1'b0;
        repeat (2) @(negedge clk);
        build_exp(0, 15);
        run_xfer(0, 15, -1, cyc);
        compare_log("R12 recovery transfer");
        check(err == 1'b1, "R12", "error flag sticky", err, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule